// File: doc/BRIEF.md
# SMBus Byte-Store Target

This block is a bus target for a two-wire SMBus/I2C segment that holds 256 bytes of storage behind one 7-bit address. It watches oversampled copies of the clock and data lines and finds START, STOP and repeated START conditions. It answers only its own address and drives the data line in open-drain fashion. The line is pulled low only for an acknowledge or for a 0 data bit.

Five transaction shapes are served. A quick command is an address followed by STOP. A send byte loads the current offset. A receive byte reads at the current offset and steps it. A write names a start location in its first byte, and the bytes after it fill memory from that location onward. A read with a command byte is a write of the location, a repeated START and then a read burst. Bursts have no length byte. A controller ends a read by NACKing a byte. A parallel preload port fills the memory while the bus is idle, for example at reset time from a boot sequencer.

Top module: `smbus_eeprom_tgt`

State machine: `ST_IDLE` waits for START. `ST_ADDR` shifts in the address byte. It moves to `ST_ADDR_ACK` on a match and to `ST_SKIP` otherwise. From `ST_ADDR_ACK` the machine goes to `ST_WR_BYTE` for a write or to `ST_RD_BYTE` for a read. `ST_WR_BYTE` and `ST_WR_ACK` alternate while the controller writes. `ST_RD_BYTE` and `ST_RD_ACK` alternate while the target sends. A NACK in `ST_RD_ACK` leads to `ST_SKIP`. STOP from any state returns to `ST_IDLE`. START from any state enters `ST_ADDR`.

## Requirements
- R1: After reset the current offset is 0, the machine is idle and the data line is not driven.
- R2: The first byte after START carries the 7-bit address in bits 7:1 and the direction in bit 0 (1 = read). An address equal to 0x50 plus DEV_INDEX is acknowledged by pulling the data line low during the ninth clock.
- R3: Any other address is not acknowledged. Bytes that follow it, up to the next START, are neither acknowledged nor stored.
- R4: A quick command (matching write address, then STOP) is acknowledged and leaves the offset and the memory unchanged.
- R5: A send byte (address, one byte, STOP) loads that byte into the current offset and writes no memory.
- R6: A receive byte returns the byte at the current offset and then adds 1 to the offset, so 255 steps to 0.
- R7: In a write, the first byte after the address is the start location. Each later byte is stored at the next location, and location 255 is followed by location 0.
- R8: A write with one or more data bytes leaves the current offset unchanged.
- R9: In a read with a command byte, the offset is loaded from the command byte at the repeated START. Bytes are returned from there on while the controller acknowledges. After a NACK the offset points one past the last byte sent.
- R10: The preload port writes its data at its address in the cycle its enable is high, while the bus is idle.
- R11: The target changes its drive on the data line only while the clock line is low. Data bits go out most significant first.
- R12: A STOP returns the machine to idle with the data line released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, sampled |
| sda_i | input | 1 | Bus data line, sampled |
| sda_drive_low_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| pre_we_i | input | 1 | Preload write enable |
| pre_addr_i | input | 8 | Preload location |
| pre_data_i | input | 8 | Preload byte |

## Verification
The bench builds the target with DEV_INDEX = 3, so it answers 0x53. This leaves 0x50 and 0x57 at either end of the address window for the no-acknowledge cases. It keeps the default two-stage synchronizer and runs each bus clock phase for ten oversampling cycles. At that rate the three-cycle edge-detection latency is visible against the driving and sampling points. This exposes any response that lands on the wrong side of a clock edge. A pattern preloaded into all 256 locations lets every returned byte be checked against a location-dependent value, including the bursts that wrap across 255.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // data moving while the clock stays high marks a bus condition
    assign start_o    = scl_s & scl_q &  sda_q & ~sda_s;
    assign stop_o     = scl_s & scl_q & ~sda_q &  sda_s;
    assign scl_rise_o =  scl_s & ~scl_q;
    assign scl_fall_o = ~scl_s &  scl_q;
endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/smbus_eeprom_tgt.sv
module smbus_eeprom_tgt
    import smbus_eeprom_pkg::*;
#(
    parameter int          DEV_INDEX   = 0,
    parameter logic [6:0]  BASE_ADDR   = 7'h50,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_drive_low_o,
    input  logic       pre_we_i,
    input  logic [7:0] pre_addr_i,
    input  logic [7:0] pre_data_i
);
    localparam int         AW      = 8;
    localparam int         DW      = 8;
    localparam int         CNT_W   = $clog2(DW + 1);
    localparam logic [6:0] MY_ADDR = BASE_ADDR + 7'(DEV_INDEX);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);

    logic scl_s, sda_s;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    tgt_state_e      state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [DW-1:0]   shreg_q, tx_q, cmd_q;
    logic [AW-1:0]   offset_q, wptr_q;
    logic            have_cmd_q, data_seen_q, mack_q;
    logic [6:0]      own_addr;
    logic            addr_hit, byte_done, bus_we;
    logic            mem_we;
    logic [AW-1:0]   mem_waddr;
    logic [DW-1:0]   mem_wdata, mem_rdata;

    line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s)
    );
    line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s)
    );

    bus_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_o(start_ev), .stop_o(stop_ev),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
    );

    assign own_addr  = MY_ADDR;
    assign addr_hit  = (shreg_q[7:1] == own_addr);
    assign byte_done = scl_fall && (bit_cnt_q == LAST_BIT);
    assign bus_we    = (state_q == ST_WR_BYTE) && byte_done && have_cmd_q
                       && !start_ev && !stop_ev;

    // preload takes the port when asserted; it is meant for idle time
    assign mem_we    = pre_we_i | bus_we;
    assign mem_waddr = pre_we_i ? pre_addr_i : wptr_q;
    assign mem_wdata = pre_we_i ? pre_data_i : shreg_q;

    byte_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(offset_q), .rdata(mem_rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) state_d = shreg_q[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = mack_q ? ST_RD_BYTE : ST_SKIP;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            tx_q        <= '1;
            cmd_q       <= '0;
            offset_q    <= '0;
            wptr_q      <= '0;
            have_cmd_q  <= 1'b0;
            data_seen_q <= 1'b0;
            mack_q      <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bit_cnt_q <= '0;
            // a lone byte after a write address becomes the new offset
            if (have_cmd_q && !data_seen_q) offset_q <= cmd_q;
            have_cmd_q  <= 1'b0;
            data_seen_q <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg_q   <= {shreg_q[DW-2:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt_q <= '0;
                        if (state_q == ST_WR_BYTE) begin
                            if (!have_cmd_q) begin
                                cmd_q      <= shreg_q;
                                wptr_q     <= shreg_q;
                                have_cmd_q <= 1'b1;
                            end else begin
                                wptr_q      <= wptr_q + 1'b1;
                                data_seen_q <= 1'b1;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && shreg_q[0]) begin
                        tx_q      <= mem_rdata;
                        bit_cnt_q <= '0;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_rise) begin
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                    end else if (byte_done) begin
                        offset_q  <= offset_q + 1'b1;
                        bit_cnt_q <= '0;
                    end else if (scl_fall) begin
                        tx_q <= {tx_q[DW-2:0], 1'b1};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_q <= ~sda_s;
                    end else if (scl_fall && mack_q) begin
                        tx_q <= mem_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_drive_low_o = 1'b1;
            ST_RD_BYTE:             sda_drive_low_o = ~tx_q[DW-1];
            default:                sda_drive_low_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/smbus_eeprom_tgt_chk.sv
module smbus_eeprom_tgt_chk
    import smbus_eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_ev,
    input logic       sda_drive_low_o,
    input tgt_state_e state_q,
    input logic [7:0] offset_q,
    input logic [7:0] shreg_q,
    input logic [6:0] own_addr
);
    // R11: drive only moves while the sampled clock is low
    a_r11_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_drive_low_o));

    // R2: acknowledge phase entered only with the own address captured
    a_r2_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ADDR_ACK) |-> (shreg_q[7:1] == own_addr));

    // R6: each sent byte steps the offset by one, modulo 256
    a_r6_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RD_ACK) |-> (offset_q == 8'($past(offset_q) + 8'd1)));

    // R8: data acknowledge in a write leaves the offset alone
    a_r8_write_keeps_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_ACK) |-> $stable(offset_q));

    // R12: STOP returns to idle
    a_r12_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state_q == ST_IDLE && !sda_drive_low_o));
endmodule

bind smbus_eeprom_tgt smbus_eeprom_tgt_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .scl_s(scl_s),
    .stop_ev(stop_ev),
    .sda_drive_low_o(sda_drive_low_o),
    .state_q(state_q),
    .offset_q(offset_q),
    .shreg_q(shreg_q),
    .own_addr(own_addr)
);

// File: tb/smbus_eeprom_tgt_bench.sv
module smbus_eeprom_tgt_bench;
    localparam int         IDX  = 3;
    localparam logic [6:0] DEV  = 7'h50 + 7'(IDX);
    localparam int         HALF = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       drv;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    wire        sda_bus = sda_m & ~drv;

    int checks = 0, fails = 0, interfere = 0;
    bit done = 1'b0, ctl_bits = 1'b0;
    logic [7:0] mem_m [256];
    int off_m = 0;

    smbus_eeprom_tgt #(.DEV_INDEX(IDX)) u_smbus_eeprom_tgt (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_drive_low_o(drv), .pre_we_i(pre_we),
        .pre_addr_i(pre_addr), .pre_data_i(pre_data)
    );

    // R11 monitor: target must not disturb controller bits while the clock is high
    always @(negedge clk) if (ctl_bits && scl_m && (sda_bus !== sda_m)) interfere++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ph(); repeat (HALF) @(negedge clk); endtask

    task automatic b_start();
        sda_m = 1; scl_m = 1; ph(); sda_m = 0; ph(); scl_m = 0; ph();
    endtask
    task automatic b_rstart();
        sda_m = 1; ph(); scl_m = 1; ph(); sda_m = 0; ph(); scl_m = 0; ph();
    endtask
    task automatic b_stop();
        sda_m = 0; ph(); scl_m = 1; ph(); sda_m = 1; ph();
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; ph(); scl_m = 1; ctl_bits = 1; ph(); ctl_bits = 0; scl_m = 0;
        end
        sda_m = 1; ph(); scl_m = 1; ph(); ack = !sda_bus; scl_m = 0; ph();
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            ph(); scl_m = 1; ph(); b[i] = sda_bus; scl_m = 0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; ph(); scl_m = 1; ph(); scl_m = 0; ph(); sda_m = 1;
    endtask

    task automatic recv_one(input string req);
        bit ack; logic [7:0] got;
        b_start(); wbyte({DEV, 1'b1}, ack);
        chk(ack, "R2", ack, 1);
        rbyte(1'b0, got);
        b_stop();
        chk(got == mem_m[off_m], req, got, mem_m[off_m]);
        off_m = (off_m + 1) % 256;
    endtask

    task automatic cmd_read(input logic [7:0] cmd, input int n, input string req);
        bit ack; logic [7:0] got;
        b_start(); wbyte({DEV, 1'b0}, ack); wbyte(cmd, ack);
        b_rstart(); wbyte({DEV, 1'b1}, ack);
        for (int k = 0; k < n; k++) begin
            rbyte(k != n - 1, got);
            chk(got == mem_m[(cmd + k) % 256], req, got, mem_m[(cmd + k) % 256]);
        end
        b_stop();
        off_m = (cmd + n) % 256;
    endtask

    task automatic cmd_write(input logic [7:0] cmd, input int n, input logic [7:0] seed);
        bit ack;
        b_start(); wbyte({DEV, 1'b0}, ack); wbyte(cmd, ack);
        for (int k = 0; k < n; k++) begin
            wbyte(seed + 8'(k * 5), ack);
            chk(ack, "R7", ack, 1);
            mem_m[(cmd + k) % 256] = seed + 8'(k * 5);
        end
        b_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit ack;
        repeat (5) @(negedge clk);
        chk(drv == 1'b0, "R1", drv, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(drv == 1'b0, "R1", drv, 0);

        // R10: preload every location
        for (int i = 0; i < 256; i++) begin
            pre_we = 1; pre_addr = 8'(i); pre_data = 8'(i * 37 + 11);
            mem_m[i] = 8'(i * 37 + 11);
            @(negedge clk);
        end
        pre_we = 0;
        ph();

        recv_one("R1");           // offset starts at 0
        recv_one("R6");           // then steps to 1

        // R3: foreign addresses get no acknowledge, bytes are dropped
        b_start(); wbyte({7'h50, 1'b0}, ack); chk(!ack, "R3", ack, 0);
        wbyte(8'h40, ack); chk(!ack, "R3", ack, 0);
        wbyte(8'hAA, ack); chk(!ack, "R3", ack, 0);
        b_stop();
        b_start(); wbyte({7'h57, 1'b1}, ack); chk(!ack, "R3", ack, 0);
        b_stop();
        recv_one("R3");           // offset untouched by foreign traffic

        // R5: send byte loads offset 255, then R6 wrap
        b_start(); wbyte({DEV, 1'b0}, ack); wbyte(8'hFF, ack);
        chk(ack, "R5", ack, 1);
        b_stop();
        off_m = 255;
        recv_one("R5");
        recv_one("R6");           // 255 -> 0 wrap

        // R7 / R8: write burst, offset unchanged
        cmd_write(8'h20, 3, 8'hC1);
        recv_one("R8");
        cmd_write(8'hFE, 4, 8'h71); // wraps to 0 and 1
        recv_one("R8");
        cmd_read(8'hFE, 4, "R7");

        // R9: command read then continue with receive byte
        cmd_read(8'h20, 3, "R9");
        recv_one("R9");
        cmd_read(8'h40, 1, "R3"); // foreign write never landed

        // R4: quick command
        b_start(); wbyte({DEV, 1'b0}, ack); chk(ack, "R4", ack, 1);
        b_stop();
        chk(drv == 1'b0, "R12", drv, 0);
        recv_one("R4");

        // R10: single preload while idle
        pre_we = 1; pre_addr = 8'h30; pre_data = 8'h5A; mem_m[8'h30] = 8'h5A;
        @(negedge clk); pre_we = 0; ph();
        cmd_read(8'h30, 2, "R10");

        chk(interfere == 0, "R11", interfere, 0);
        chk(drv == 1'b0, "R12", drv, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule